// File: doc/BRIEF.md
# SDRAM Read-Interrupting Write Sequencer

This block issues column commands to a two-bank single-data-rate SDRAM whose rows are already open. A read request produces a READ command and a four-beat burst whose data comes back after the programmed CAS latency (2 or 3 cycles, chosen at run time on `cas_lat`). A write request can arrive while that burst is still coming back. When it does, the sequencer cuts the read short. It raises both byte-mask lines long enough that every read beat from the turnaround cycle onward is suppressed. It then issues the WRITE with its first data beat in the same cycle, so the memory and the controller never drive the data pins at once.

Requests use a valid/ready handshake and carry direction, bank, column, four write beats and a byte mask. A request aimed at a bank whose `bank_act` bit is low is taken off the interface but refused: no command is issued and `req_reject` pulses. Read beats that reach the pins are returned on `rd_data` with `rd_valid` and their beat index. Beats that were cut off are never reported.

Top module: `sdr_rdwr_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `sd_cmd` is NOP (4'b0111 on {CS#,RAS#,CAS#,WE#}), `sd_dq_oe`, `sd_dqm` and `rd_valid` are 0, and `req_ready` is 1 when no request is pending.
- R2: A read accepted at the end of cycle a puts READ (4'b0101) with the request's bank and column on the bus in cycle a+1, with `sd_dqm` at 0.
- R3: With CAS latency L (`cas_lat` = 2 or 3) and a READ in cycle T, the beat on `sd_dq_in` in cycle T+L+k is reported in cycle T+L+k+1 with `rd_valid`=1 and `rd_beat`=k.
- R4: A request whose bank has its `bank_act` bit low issues no command (`sd_cmd` stays NOP), and `req_reject` is 1 for exactly the following cycle.
- R5: A write accepted at the end of cycle b with no read beat due in cycle b or later puts WRITE (4'b0100) on the bus in cycle b+1. Beat 0 of the write data is on `sd_dq_out` in that same cycle and beats 1..3 follow. `sd_dq_oe` is 1 in exactly those four cycles.
- R6: A write accepted at the end of cycle b while a read beat is still due in cycle b or later holds NOP with `sd_dqm` all ones in cycles b+1..b+3 and issues WRITE in cycle b+4. WRITE never directly follows READ.
- R7: When a read is interrupted by a write accepted at the end of cycle b, read beats due in cycle b+2 or earlier are reported and beats due in cycle b+3 or later are never reported.
- R8: The memory never drives the data pins in a cycle where `sd_dq_oe` is 1 or in the cycle just before it.
- R9: During the four write beats `sd_dqm` equals the request's `req_bmask`, where bit i masks data bits 8i+7..8i.
- R10: `req_ready` is 0 from the cycle after a write is accepted through its last data beat. It is also 0 for a read request while beats of an earlier read are still due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cas_lat | input | 2 | CAS latency, 2 or 3, changed only while idle |
| bank_act | input | NBANK | Bit per bank, 1 when that bank has an open row |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_wdata | input | BL*DQ_W | Write beats, beat k in bits k*DQ_W upward |
| req_bmask | input | NBYTE | Byte mask applied to every write beat |
| req_reject | output | 1 | Pulses when a request to an idle bank is refused |
| sd_cmd | output | 4 | {CS#,RAS#,CAS#,WE#} command |
| sd_bank | output | BANK_W | Bank address |
| sd_col | output | COL_W | Column address |
| sd_dqm | output | NBYTE | Byte mask lines |
| sd_dq_oe | output | 1 | Controller drives the data pins |
| sd_dq_out | output | DQ_W | Write data |
| sd_dq_in | input | DQ_W | Data from the memory |
| rd_valid | output | 1 | Read beat valid |
| rd_beat | output | BEAT_W | Index of the reported beat |
| rd_data | output | DQ_W | Read beat data |

## Verification
The in-flight read state is a shift register of due beats. If it is wrong, a beat appears with the wrong index or data one cycle after the pins, or a cut beat shows as valid. It can also leave the masking decision wrong, and then the memory model sees its own drive overlap `sd_dq_oe` in the write cycle or the cycle before. A wrong sequencer state shows within one cycle of the write handshake: WRITE lands at the wrong offset from acceptance, or the byte-mask lines are not all ones for the three cycles ahead of it. Every scenario also checks that no expected read beat is left unreported.

// File: rtl/sdr_seq_pkg.sv
// Shared encodings for the read/write column sequencer.
// Assumes command pins ordered {CS#, RAS#, CAS#, WE#}.
package sdr_seq_pkg;
    // Cycles from byte-mask sampling to suppressed read data.
    localparam int DQM_LAT = 2;

    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100
    } sd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MASK,
        ST_WRITE
    } seq_st_e;
endpackage

// File: rtl/sdr_rd_track.sv
// Tracks read beats in flight and captures them from the data pins.
// Bit j of the due vector means a beat is on the pins j cycles from now.
// Assumes cas_lat is 2..CL_MAX and stable while a burst is in flight.
module sdr_rd_track
    import sdr_seq_pkg::*;
#(
    parameter int DQ_W   = 16,
    parameter int BL     = 4,
    parameter int CL_MAX = 3,
    localparam int BEAT_W = $clog2(BL),
    localparam int DUE_W  = CL_MAX + BL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cas_lat,
    input  logic              ld_read,
    input  logic              cancel,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              busy,
    output logic              due_now,
    output logic              rd_valid,
    output logic [BEAT_W-1:0] rd_beat,
    output logic [DQ_W-1:0]   rd_data
);
    localparam logic [DUE_W-1:0] BURST_BITS = {{(DUE_W-BL){1'b0}}, {BL{1'b1}}};
    localparam logic [DUE_W-1:0] KEEP_BITS  = {{(DUE_W-DQM_LAT){1'b0}}, {DQM_LAT{1'b1}}};

    logic [DUE_W-1:0]  due;
    logic [BEAT_W-1:0] idx;

    assign busy    = |due;
    assign due_now = due[0];

    // Schedule, age and cut the beats of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due <= '0;
        end else if (ld_read) begin
            due <= BURST_BITS << cas_lat;
        end else if (cancel) begin
            due <= (due >> 1) & KEEP_BITS;
        end else begin
            due <= due >> 1;
        end
    end

    // Count beats and register each one that reaches the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            rd_valid <= 1'b0;
            rd_beat  <= '0;
            rd_data  <= '0;
        end else begin
            rd_valid <= due[0];
            if (ld_read) begin
                idx <= '0;
            end else if (due[0]) begin
                idx <= idx + 1'b1;
            end
            if (due[0]) begin
                rd_beat <= idx;
                rd_data <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sdr_cmd_fsm.sv
// Request handshake, command generation, masking window and write burst.
// Assumes rd_busy reports any read beat due in the current cycle or later.
module sdr_cmd_fsm
    import sdr_seq_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int COL_W = 8,
    parameter int NBANK = 2,
    parameter int BL    = 4,
    localparam int BANK_W = $clog2(NBANK),
    localparam int NBYTE  = DQ_W / 8,
    localparam int BEAT_W = $clog2(BL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NBANK-1:0]   bank_act,
    input  logic               rd_busy,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [COL_W-1:0]   req_col,
    input  logic [BL*DQ_W-1:0] req_wdata,
    input  logic [NBYTE-1:0]   req_bmask,
    output logic               req_reject,
    output logic               ld_read,
    output logic               cancel,
    output logic [3:0]         sd_cmd,
    output logic [BANK_W-1:0]  sd_bank,
    output logic [COL_W-1:0]   sd_col,
    output logic [NBYTE-1:0]   sd_dqm,
    output logic               sd_dq_oe,
    output logic [DQ_W-1:0]    sd_dq_out
);
    localparam int MASK_CYC = DQM_LAT + 1;
    localparam int MCNT_W   = $clog2(MASK_CYC);
    localparam logic [MCNT_W-1:0] MASK_LAST = MCNT_W'(MASK_CYC - 1);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BL - 1);

    seq_st_e            st;
    sd_cmd_e            cmd_q;
    logic [MCNT_W-1:0]  mcnt;
    logic [BEAT_W-1:0]  wbeat;
    logic [BEAT_W-1:0]  next_beat;
    logic [BL*DQ_W-1:0] wdata_q;
    logic [NBYTE-1:0]   bmask_q;
    logic               acc;
    logic               bank_ok;
    logic               wr_acc;

    // Handshake and decode of the request presented this cycle.
    always_comb begin
        req_ready = (st == ST_IDLE) && !(!req_write && rd_busy);
        acc       = req_valid && req_ready;
        bank_ok   = bank_act[req_bank];
        ld_read   = acc && !req_write && bank_ok;
        wr_acc    = acc && req_write && bank_ok;
        cancel    = wr_acc && rd_busy;
        next_beat = wbeat + 1'b1;
    end

    assign sd_cmd = cmd_q;

    // Sequencer state, command bus and data-pin drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cmd_q      <= CMD_NOP;
            mcnt       <= '0;
            wbeat      <= '0;
            wdata_q    <= '0;
            bmask_q    <= '0;
            sd_bank    <= '0;
            sd_col     <= '0;
            sd_dqm     <= '0;
            sd_dq_oe   <= 1'b0;
            sd_dq_out  <= '0;
            req_reject <= 1'b0;
        end else begin
            cmd_q      <= CMD_NOP;
            req_reject <= 1'b0;
            case (st)
                ST_IDLE: begin
                    sd_dqm   <= '0;
                    sd_dq_oe <= 1'b0;
                    if (acc && !bank_ok) begin
                        req_reject <= 1'b1;
                    end
                    if (ld_read) begin
                        cmd_q   <= CMD_RD;
                        sd_bank <= req_bank;
                        sd_col  <= req_col;
                    end
                    if (wr_acc) begin
                        wdata_q <= req_wdata;
                        bmask_q <= req_bmask;
                        sd_bank <= req_bank;
                        sd_col  <= req_col;
                        wbeat   <= '0;
                        if (rd_busy) begin
                            st     <= ST_MASK;
                            mcnt   <= '0;
                            sd_dqm <= '1;
                        end else begin
                            st        <= ST_WRITE;
                            cmd_q     <= CMD_WR;
                            sd_dq_oe  <= 1'b1;
                            sd_dq_out <= req_wdata[DQ_W-1:0];
                            sd_dqm    <= req_bmask;
                        end
                    end
                end
                ST_MASK: begin
                    sd_dqm <= '1;
                    if (mcnt == MASK_LAST) begin
                        st        <= ST_WRITE;
                        cmd_q     <= CMD_WR;
                        sd_dq_oe  <= 1'b1;
                        sd_dq_out <= wdata_q[DQ_W-1:0];
                        sd_dqm    <= bmask_q;
                    end else begin
                        mcnt <= mcnt + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (wbeat == BEAT_LAST) begin
                        st       <= ST_IDLE;
                        sd_dq_oe <= 1'b0;
                        sd_dqm   <= '0;
                    end else begin
                        wbeat     <= next_beat;
                        sd_dq_out <= wdata_q[next_beat*DQ_W +: DQ_W];
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdr_rdwr_seq.sv
// Top: column-command sequencer that lets a write cut a read burst short.
// Assumes target rows are opened elsewhere and bank_act reflects them.
module sdr_rdwr_seq #(
    parameter int DQ_W   = 16,
    parameter int COL_W  = 8,
    parameter int NBANK  = 2,
    parameter int BL     = 4,
    parameter int CL_MAX = 3,
    localparam int BANK_W = $clog2(NBANK),
    localparam int NBYTE  = DQ_W / 8,
    localparam int BEAT_W = $clog2(BL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cas_lat,
    input  logic [NBANK-1:0]   bank_act,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [BANK_W-1:0]  req_bank,
    input  logic [COL_W-1:0]   req_col,
    input  logic [BL*DQ_W-1:0] req_wdata,
    input  logic [NBYTE-1:0]   req_bmask,
    output logic               req_reject,
    output logic [3:0]         sd_cmd,
    output logic [BANK_W-1:0]  sd_bank,
    output logic [COL_W-1:0]   sd_col,
    output logic [NBYTE-1:0]   sd_dqm,
    output logic               sd_dq_oe,
    output logic [DQ_W-1:0]    sd_dq_out,
    input  logic [DQ_W-1:0]    sd_dq_in,
    output logic               rd_valid,
    output logic [BEAT_W-1:0]  rd_beat,
    output logic [DQ_W-1:0]    rd_data
);
    logic rd_busy;
    logic rd_due_now;
    logic ld_read;
    logic cancel;

    sdr_rd_track #(.DQ_W(DQ_W), .BL(BL), .CL_MAX(CL_MAX)) u_rd (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
        .ld_read(ld_read), .cancel(cancel), .dq_in(sd_dq_in),
        .busy(rd_busy), .due_now(rd_due_now),
        .rd_valid(rd_valid), .rd_beat(rd_beat), .rd_data(rd_data)
    );

    sdr_cmd_fsm #(.DQ_W(DQ_W), .COL_W(COL_W), .NBANK(NBANK), .BL(BL)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bank_act(bank_act), .rd_busy(rd_busy),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_col(req_col), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .req_reject(req_reject),
        .ld_read(ld_read), .cancel(cancel),
        .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_col(sd_col), .sd_dqm(sd_dqm),
        .sd_dq_oe(sd_dq_oe), .sd_dq_out(sd_dq_out)
    );
endmodule

// File: rtl/sdr_rdwr_seq_chk.sv
// Protocol checker bound to the sequencer top.
// Assumes the command encodings of sdr_seq_pkg.
module sdr_rdwr_seq_chk
    import sdr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cas_lat,
    input logic [3:0] sd_cmd,
    input logic       sd_dq_oe,
    input logic       req_ready,
    input logic       req_reject,
    input logic       rd_due_now
);
    // R3: only the two supported latencies are in use
    a_r3_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_lat == 2'd2) || (cas_lat == 2'd3));

    // R8: controller drive never meets a read beat on the pins
    a_r8_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> !rd_due_now);

    // R8: an idle cycle separates read output from write input
    a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        rd_due_now |=> !sd_dq_oe);

    // R5: write command carries its first data beat
    a_r5_data_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_WR) |-> sd_dq_oe);

    // R6: at least one cycle between READ and WRITE
    a_r6_tccd: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cmd == CMD_RD) |=> (sd_cmd != CMD_WR));

    // R10: no new request while write data is on the pins
    a_r10_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> !req_ready);

    // R4: a refused request leaves the command bus idle
    a_r4_refuse_nop: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |-> (sd_cmd == CMD_NOP));
endmodule

bind sdr_rdwr_seq sdr_rdwr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .sd_cmd(sd_cmd),
    .sd_dq_oe(sd_dq_oe), .req_ready(req_ready), .req_reject(req_reject),
    .rd_due_now(rd_due_now)
);

// File: tb/sim_sdr_rdwr_seq.sv
`timescale 1ns/1ps
// Scoreboard bench with a behavioural memory model on the data pins.
module sim_sdr_rdwr_seq;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] RD  = 4'b0101;
    localparam logic [3:0] WR  = 4'b0100;

    typedef struct { int beat; logic [15:0] data; } rexp_t;
    typedef struct { int cyc; logic [63:0] data; logic [1:0] mask; bit masked; } wexp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  cas_lat = 2'd2;
    logic [1:0]  bank_act = 2'b11;
    logic        req_valid = 0;
    logic        req_ready;
    logic        req_write = 0;
    logic [0:0]  req_bank = '0;
    logic [7:0]  req_col = '0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic        req_reject;
    logic [3:0]  sd_cmd;
    logic [0:0]  sd_bank;
    logic [7:0]  sd_col;
    logic [1:0]  sd_dqm;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = '0;
    logic        rd_valid;
    logic [1:0]  rd_beat;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    rexp_t rq[$];
    wexp_t wq[$];

    sdr_rdwr_seq u0 (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [0:0] b, input logic [7:0] c, input int k);
        return {3'b101, b, c, 4'(k)};
    endfunction

    // Memory model: answers reads, obeys byte-mask latency and write termination.
    bit          m_on = 0;
    int          m_t0 = 0;
    logic [0:0]  m_bank;
    logic [7:0]  m_col;
    logic [1:0]  dh1 = 0, dh2 = 0, dh3 = 0;
    bit          drv_cur = 0, drv_last = 0;
    int          wr_k = -1;
    wexp_t       wcur;
    always @(posedge clk) begin
        int p;
        int k;
        bit drive;
        p = cyc;
        if (!rst_n) begin
            m_on = 0; wr_k = -1; drv_cur = 0; drv_last = 0;
            dh1 = 0; dh2 = 0; dh3 = 0;
            sd_dq_in <= '0;
        end else begin
            if (sd_dq_oe) chk(!(drv_cur || drv_last), "R8 pins", {drv_last, drv_cur}, 0);
            if (sd_cmd == WR) begin
                if (wq.size() == 0) chk(0, "R5 unexpected write", p, 0);
                else begin
                    wcur = wq.pop_front();
                    chk(p == wcur.cyc, wcur.masked ? "R6 write cycle" : "R5 write cycle", p, wcur.cyc);
                    if (wcur.masked) chk({dh1, dh2, dh3} == 6'h3f, "R6 mask window", {dh1, dh2, dh3}, 6'h3f);
                    wr_k = 0;
                end
                m_on = 0;
            end
            if (wr_k >= 0) begin
                chk(sd_dq_oe && sd_dq_out == wcur.data[wr_k*16 +: 16], "R5 write beat", sd_dq_out, wcur.data[wr_k*16 +: 16]);
                chk(sd_dqm == wcur.mask, "R9 write mask", sd_dqm, wcur.mask);
                wr_k++;
                if (wr_k == 4) wr_k = -1;
            end else if (sd_dq_oe) begin
                chk(0, "R5 drive outside burst", 1, 0);
            end
            if (sd_cmd == RD) begin
                m_on = 1; m_t0 = p + int'(cas_lat); m_bank = sd_bank; m_col = sd_col;
            end
            k = p + 1 - m_t0;
            drive = m_on && k >= 0 && k < 4 && dh1 == 2'b00;
            if (m_on && k == 3) m_on = 0;
            dh3 = dh2; dh2 = dh1; dh1 = sd_dqm;
            drv_last = drv_cur; drv_cur = drive;
            sd_dq_in <= drive ? pat(m_bank, m_col, k) : 16'h0;
        end
        cyc = cyc + 1;
    end

    // Monitor: pops expected read beats as the design reports them.
    always @(negedge clk) begin
        rexp_t e;
        if (rst_n && rd_valid) begin
            if (rq.size() == 0) chk(0, "R7 beat reported after cut", rd_beat, 0);
            else begin
                e = rq.pop_front();
                chk(rd_beat == 2'(e.beat) && rd_data == e.data, "R3 read beat", {rd_beat, rd_data}, {2'(e.beat), e.data});
            end
        end
    end

    task automatic send(input bit wr, input logic [0:0] b, input logic [7:0] c,
                        input logic [63:0] wd, input logic [1:0] bm, output int acc);
        @(negedge clk);
        req_write = wr; req_bank = b; req_col = c; req_wdata = wd; req_bmask = bm; req_valid = 1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc = cyc;
        @(negedge clk);
        req_valid = 0;
    endtask

    // Read, optionally interrupted by a write accepted gap cycles later.
    task automatic rd_wr(input logic [1:0] cl, input logic [0:0] b, input logic [7:0] c,
                         input int gap, input logic [63:0] wd, input logic [1:0] bm);
        int a;
        int bcyc;
        int lastb;
        wexp_t w;
        @(negedge clk);
        cas_lat = cl;
        send(0, b, c, '0, '0, a);
        chk(sd_cmd == RD && sd_bank == b && sd_col == c && sd_dqm == 2'b00, "R2 read command", {sd_cmd, sd_bank, sd_col}, {RD, b, c});
        for (int k = 0; k < 4; k++) begin
            if (gap == 0 || k <= gap + 1 - int'(cl)) rq.push_back('{k, pat(b, c, k)});
        end
        if (gap > 0) begin
            for (int i = 1; i < gap; i++) @(negedge clk);
            req_write = 1; req_bank = b; req_col = c + 8'd1; req_wdata = wd; req_bmask = bm; req_valid = 1;
            #1;
            chk(req_ready, "R10 write taken during read", req_ready, 1);
            bcyc = cyc;
            lastb = a + 1 + int'(cl) + 3;
            w.masked = (lastb >= bcyc);
            w.cyc = w.masked ? bcyc + 4 : bcyc + 1;
            w.data = wd; w.mask = bm;
            wq.push_back(w);
            @(negedge clk);
            req_valid = 0;
            chk(!req_ready, "R10 ready during write", req_ready, 0);
        end
        repeat (14) @(negedge clk);
        chk(rq.size() == 0, "R7 expected beats missing", rq.size(), 0);
        chk(wq.size() == 0, "R5 write not issued", wq.size(), 0);
        rq.delete();
    endtask

    task automatic wr_only(input logic [0:0] b, input logic [63:0] wd, input logic [1:0] bm);
        int a;
        wexp_t w;
        @(negedge clk);
        req_write = 1; req_bank = b; req_col = 8'h40; req_wdata = wd; req_bmask = bm; req_valid = 1;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        a = cyc;
        w.cyc = a + 1; w.data = wd; w.mask = bm; w.masked = 0;
        wq.push_back(w);
        @(negedge clk);
        req_valid = 0;
        for (int i = 1; i <= 4; i++) begin
            chk(!req_ready, "R10 ready low in write", req_ready, 0);
            @(negedge clk);
        end
        chk(req_ready, "R10 ready back", req_ready, 1);
        repeat (4) @(negedge clk);
        chk(wq.size() == 0, "R5 write not issued", wq.size(), 0);
    endtask

    initial begin
        int a;
        repeat (3) @(negedge clk);
        chk(sd_cmd == NOP && !sd_dq_oe && sd_dqm == 0 && !rd_valid, "R1 reset state", {sd_cmd, sd_dq_oe, sd_dqm, rd_valid}, {NOP, 4'h0});
        rst_n = 1;
        @(negedge clk);
        chk(sd_cmd == NOP && !sd_dq_oe && req_ready, "R1 after reset", {sd_cmd, sd_dq_oe, req_ready}, {NOP, 2'b01});

        rd_wr(2'd2, 1'b0, 8'h11, 0, '0, '0);
        rd_wr(2'd3, 1'b1, 8'h22, 0, '0, '0);
        wr_only(1'b0, 64'h1111_2222_3333_4444, 2'b00);
        wr_only(1'b1, 64'hA5A5_5A5A_0F0F_F0F0, 2'b10);
        rd_wr(2'd2, 1'b0, 8'h30, 1, 64'hDEAD_BEEF_CAFE_F00D, 2'b00);
        rd_wr(2'd3, 1'b1, 8'h31, 1, 64'h0102_0304_0506_0708, 2'b01);
        rd_wr(2'd2, 1'b1, 8'h32, 2, 64'h1357_9BDF_2468_ACE0, 2'b00);
        rd_wr(2'd3, 1'b0, 8'h33, 3, 64'hFFFF_0000_AAAA_5555, 2'b00);
        rd_wr(2'd3, 1'b0, 8'h34, 4, 64'h1234_5678_9ABC_DEF0, 2'b11);
        rd_wr(2'd2, 1'b0, 8'h35, 6, 64'h0F0F_1E1E_2D2D_3C3C, 2'b00);
        rd_wr(2'd2, 1'b1, 8'h36, 7, 64'h7777_6666_5555_4444, 2'b00);
        rd_wr(2'd3, 1'b1, 8'h37, 8, 64'h8888_9999_AAAA_BBBB, 2'b00);

        // R10: a second read waits while beats of the first are due
        @(negedge clk);
        cas_lat = 2'd3;
        send(0, 1'b0, 8'h50, '0, '0, a);
        for (int k = 0; k < 4; k++) rq.push_back('{k, pat(1'b0, 8'h50, k)});
        req_write = 0; req_valid = 1;
        #1;
        chk(!req_ready, "R10 read held off", req_ready, 0);
        req_valid = 0;
        repeat (12) @(negedge clk);
        chk(rq.size() == 0, "R3 beats of held read", rq.size(), 0);

        // R4: requests to a closed bank are refused
        bank_act = 2'b01;
        send(0, 1'b1, 8'h60, '0, '0, a);
        chk(req_reject && sd_cmd == NOP, "R4 read refused", {req_reject, sd_cmd}, {1'b1, NOP});
        @(negedge clk);
        chk(!req_reject && sd_cmd == NOP, "R4 single pulse", {req_reject, sd_cmd}, {1'b0, NOP});
        send(1, 1'b1, 8'h61, 64'h1, 2'b00, a);
        chk(req_reject && sd_cmd == NOP && !sd_dq_oe, "R4 write refused", {req_reject, sd_cmd, sd_dq_oe}, {1'b1, NOP, 1'b0});
        repeat (6) @(negedge clk);
        chk(!rd_valid && !sd_dq_oe, "R4 nothing issued", {rd_valid, sd_dq_oe}, 0);
        bank_act = 2'b11;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule